// File: doc/BRIEF.md
# Sixteen-bit arithmetic, logic and shift unit

This unit is the combinational datapath of a processor execute stage. In one evaluation it adds, subtracts, applies a bitwise logical function, or shifts and rotates a 16-bit operand by any distance from 0 to 15. Alongside the result it reports four condition flags: zero, negative, carry and overflow. An external carry input links partial operations into a multi-word add or subtract chain.

A mode input selects word or byte width. In byte mode the operation acts on the low byte of each operand. The high byte of the result is a copy of operand A's high byte, so a byte write to a register leaves its upper half intact. All flags then refer to bit 7 and to the low byte. A caller registers the outputs wherever its pipeline needs them, because the unit itself holds no state.

Top module: `alu16_core`

## Requirements
- R1: Opcode 0 (add) returns A+B, and opcode 1 (add with carry) returns A+B+carry_i. The carry flag is the carry out of the active top bit (bit 15 in word mode, bit 7 in byte mode).
- R2: Opcode 2 (subtract) returns A-B, and opcode 3 (subtract with borrow) returns A-B-carry_i. The carry flag is 1 when a borrow occurs, meaning the unsigned A is less than B plus the borrow-in.
- R3: For opcodes 0 to 3, overflow is the two's-complement overflow at the active top bit. For every other opcode, overflow is 0.
- R4: Opcodes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT A respectively, each with carry and overflow at 0.
- R5: When byte_mode_i is 1, bits 7:0 of the result come from the low bytes of the operands and bits 15:8 equal A[15:8]. Negative is bit 7 of the result, and zero is set only when bits 7:0 are all 0.
- R6: When byte_mode_i is 0, negative is bit 15 of the result, and zero is set only when all 16 result bits are 0.
- R7: Opcode 8 shifts left and opcode 9 shifts right logically by shamt_i places, filling with zeros. Carry is the last bit moved out of the active width.
- R8: Opcode 10 shifts right arithmetically by shamt_i places, filling with copies of the active top bit. Carry is the last bit moved out.
- R9: Opcode 11 rotates left and opcode 12 rotates right by shamt_i places within the active width. Carry is the last bit carried around, which is result bit 0 for a left rotate and the active top bit for a right rotate.
- R10: A shift or rotate by 0 leaves the operand unchanged and clears carry.
- R11: In byte mode, a logical or arithmetic shift by 8 or more places acts on the 8-bit field. Bits shifted past the field are lost, and carry becomes 0 (logical) or the sign (arithmetic) once the distance exceeds 8. A rotate distance is taken modulo 8.
- R12: Opcodes 13, 14 and 15 are undefined. They return A unchanged, with all four flags at 0.
- R13: carry_i has no effect on opcodes other than 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand, and the operand that is shifted |
| b_i | input | 16 | Second operand |
| op_i | input | 4 | Operation code (see requirements) |
| byte_mode_i | input | 1 | 1 selects 8-bit operation on the low byte |
| carry_i | input | 1 | Carry or borrow in for chained arithmetic |
| shamt_i | input | 4 | Shift or rotate distance, 0 to 15 |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | Active bits of the result are all zero |
| neg_o | output | 1 | Active top bit of the result |
| carry_o | output | 1 | Carry, borrow or last bit shifted out |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest cases to reach are byte-mode shifts whose distance runs past the 8-bit field. In these cases the carry must come from a position beyond the field, or fall back to zero or to the sign. The word datapath never exercises that path, so a dedicated task sweeps every distance from 0 to 15 for each shift kind in byte mode. It uses operands whose high byte is non-zero, which exposes any leakage of upper bits. Borrow-in at the exact point where A equals B is also targeted directly, because only there does the borrow flip the carry and the sign together.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_ASR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_RSV0 = 4'd13,
        OP_RSV1 = 4'd14,
        OP_RSV2 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ASR) ||
               (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         use_cin_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff_d;
    logic         ci_d;
    logic [W:0]   wide_d;

    always_comb begin
        b_eff_d = sub_i ? ~b_i : b_i;
        ci_d    = sub_i ? ~(use_cin_i & cin_i) : (use_cin_i & cin_i);
        wide_d  = {1'b0, a_i} + {1'b0, b_eff_d} + {{W{1'b0}}, ci_d};
        sum_o   = wide_d[W-1:0];
        cout_o  = sub_i ? ~wide_d[W] : wide_d[W];
        ovf_o   = (a_i[W-1] == b_eff_d[W-1]) && (wide_d[W-1] != a_i[W-1]);
    end

    // R2: a plain subtract borrows exactly when A < B
    always_comb begin
        if (sub_i && !use_cin_i) begin
            p_borrow_r2: assert (cout_o == (a_i < b_i))
                else $error("borrow flag disagrees with operand order");
        end
        // R1: a plain add carries exactly when the sum wraps below A
        if (!sub_i && !use_cin_i) begin
            p_carry_r1: assert (cout_o == (sum_o < a_i))
                else $error("carry flag disagrees with wrapped sum");
        end
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = 4
) (
    input  logic [W-1:0]   a_i,
    input  logic [SHW-1:0] amt_i,
    input  alu_op_e        op_i,
    output logic [W-1:0]   res_o,
    output logic           cout_o
);
    localparam int RW = $clog2(W);

    logic [W:0]          left_d;
    logic [W:0]          right_d;
    logic signed [W:0]   arith_d;
    logic [2*W-1:0]      rotl_d;
    logic [2*W-1:0]      rotr_d;
    logic [RW-1:0]       rot_amt_d;

    always_comb begin
        rot_amt_d = amt_i[RW-1:0];
        left_d    = {1'b0, a_i} << amt_i;
        right_d   = {a_i, 1'b0} >> amt_i;
        arith_d   = $signed({a_i, 1'b0}) >>> amt_i;
        rotl_d    = {a_i, a_i} << rot_amt_d;
        rotr_d    = {a_i, a_i} >> rot_amt_d;
        res_o     = a_i;
        cout_o    = 1'b0;
        unique case (op_i)
            OP_SHL: begin
                res_o  = left_d[W-1:0];
                cout_o = left_d[W];
            end
            OP_SHR: begin
                res_o  = right_d[W:1];
                cout_o = right_d[0];
            end
            OP_ASR: begin
                res_o  = arith_d[W:1];
                cout_o = arith_d[0];
            end
            OP_ROL: begin
                res_o  = rotl_d[2*W-1:W];
                cout_o = rotl_d[W];
            end
            OP_ROR: begin
                res_o  = rotr_d[W-1:0];
                cout_o = rotr_d[W-1];
            end
            default: begin
                res_o  = a_i;
                cout_o = 1'b0;
            end
        endcase
        if (amt_i == '0) begin
            cout_o = 1'b0;
        end
    end

    always_comb begin
        // R10: zero distance is the identity with carry cleared
        if (amt_i == '0 && is_shift(op_i)) begin
            p_zero_amt_r10: assert (res_o == a_i && !cout_o)
                else $error("zero-distance shift altered operand");
        end
        // R9: a rotate keeps every bit, so the population count is preserved
        if (op_i == OP_ROL || op_i == OP_ROR) begin
            p_rot_pop_r9: assert ($countones(res_o) == $countones(a_i))
                else $error("rotate lost or created bits");
        end
    end
endmodule

// File: rtl/alu16_lane.sv
module alu16_lane
    import alu16_pkg::*;
#(
    parameter int W   = 16,
    parameter int SHW = 4
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  alu_op_e        op_i,
    input  logic           carry_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   res_o,
    output alu_flags_t     flags_o
);
    logic [W-1:0] sum_d;
    logic         sum_c_d;
    logic         sum_v_d;
    logic [W-1:0] log_d;
    logic [W-1:0] sh_d;
    logic         sh_c_d;
    logic         is_sub_d;
    logic         use_cin_d;

    always_comb begin
        is_sub_d  = (op_i == OP_SUB) || (op_i == OP_SUBC);
        use_cin_d = (op_i == OP_ADDC) || (op_i == OP_SUBC);
    end

    alu16_addsub #(.W(W)) u_addsub (
        .a_i       (a_i),
        .b_i       (b_i),
        .sub_i     (is_sub_d),
        .use_cin_i (use_cin_d),
        .cin_i     (carry_i),
        .sum_o     (sum_d),
        .cout_o    (sum_c_d),
        .ovf_o     (sum_v_d)
    );

    alu16_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .res_o (log_d)
    );

    alu16_shift #(.W(W), .SHW(SHW)) u_shift (
        .a_i    (a_i),
        .amt_i  (shamt_i),
        .op_i   (op_i),
        .res_o  (sh_d),
        .cout_o (sh_c_d)
    );

    always_comb begin
        res_o   = a_i;
        flags_o = '0;
        unique case (op_i)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
                res_o     = sum_d;
                flags_o.c = sum_c_d;
                flags_o.v = sum_v_d;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                res_o = log_d;
            end
            OP_SHL, OP_SHR, OP_ASR, OP_ROL, OP_ROR: begin
                res_o     = sh_d;
                flags_o.c = sh_c_d;
            end
            default: begin
                res_o = a_i;
            end
        endcase
        if (op_i < OP_RSV0) begin
            flags_o.z = (res_o == '0);
            flags_o.n = res_o[W-1];
        end
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    input  logic             byte_mode_i,
    input  logic             carry_i,
    input  logic [SHW-1:0]   shamt_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             neg_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int HALF = WIDTH / 2;

    alu_op_e          op_d;
    logic [WIDTH-1:0] word_res_d;
    alu_flags_t       word_flags_d;
    logic [HALF-1:0]  byte_res_d;
    alu_flags_t       byte_flags_d;
    alu_flags_t       flags_d;

    assign op_d = alu_op_e'(op_i);

    alu16_lane #(.W(WIDTH), .SHW(SHW)) u_word (
        .a_i     (a_i),
        .b_i     (b_i),
        .op_i    (op_d),
        .carry_i (carry_i),
        .shamt_i (shamt_i),
        .res_o   (word_res_d),
        .flags_o (word_flags_d)
    );

    alu16_lane #(.W(HALF), .SHW(SHW)) u_byte (
        .a_i     (a_i[HALF-1:0]),
        .b_i     (b_i[HALF-1:0]),
        .op_i    (op_d),
        .carry_i (carry_i),
        .shamt_i (shamt_i),
        .res_o   (byte_res_d),
        .flags_o (byte_flags_d)
    );

    always_comb begin
        if (byte_mode_i) begin
            result_o = {a_i[WIDTH-1:HALF], byte_res_d};
            flags_d  = byte_flags_d;
        end else begin
            result_o = word_res_d;
            flags_d  = word_flags_d;
        end
        zero_o  = flags_d.z;
        neg_o   = flags_d.n;
        carry_o = flags_d.c;
        ovf_o   = flags_d.v;
    end

    always_comb begin
        // R5: byte mode preserves the upper half of operand A
        if (byte_mode_i) begin
            p_keep_high_r5: assert (result_o[WIDTH-1:HALF] == a_i[WIDTH-1:HALF])
                else $error("byte mode disturbed the high byte");
        end
        // R6: word mode zero flag covers the whole result
        if (!byte_mode_i && op_i < 4'd13) begin
            p_zero_word_r6: assert (zero_o == (result_o == '0))
                else $error("zero flag disagrees with word result");
        end
        // R4: logical operations leave carry and overflow clear
        if (is_logic(op_d)) begin
            p_logic_flags_r4: assert (!carry_o && !ovf_o)
                else $error("logical op raised carry or overflow");
        end
        // R3: overflow only ever comes from add or subtract
        if (op_i > 4'd3) begin
            p_no_overflow_r3: assert (!ovf_o)
                else $error("overflow raised by non-arithmetic op");
        end
        // R12: undefined codes pass A with flags clear
        if (op_i > 4'd12) begin
            p_undef_r12: assert (result_o == a_i && !zero_o && !neg_o && !carry_o && !ovf_o)
                else $error("undefined opcode produced a result");
        end
    end
endmodule

// File: tb/alu16_core_test.sv
module alu16_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a, b;
    logic [3:0]  op;
    logic        bm, ci;
    logic [3:0]  k;
    logic [15:0] res;
    logic        z, n, c, v;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    alu16_core uut (
        .a_i(a), .b_i(b), .op_i(op), .byte_mode_i(bm), .carry_i(ci),
        .shamt_i(k), .result_o(res), .zero_o(z), .neg_o(n),
        .carry_o(c), .ovf_o(v)
    );

    // Behavioural model written from the requirements: bit-serial shifting
    function automatic logic [19:0] model(input logic [3:0] fop, input logic [15:0] fa,
                                          input logic [15:0] fb, input logic fci,
                                          input logic fbm, input logic [3:0] fk);
        int          w;
        logic [16:0] msk, aa, bb, r, t;
        logic        fc, fv, fz, fn, sg;
        w   = fbm ? 8 : 16;
        msk = (17'd1 << w) - 17'd1;
        aa  = {1'b0, fa} & msk;
        bb  = {1'b0, fb} & msk;
        r   = aa;
        fc  = 1'b0;
        fv  = 1'b0;
        if (fop > 4'd12) return {fa, 4'b0000};
        case (fop)
            4'd0, 4'd1: begin
                t  = aa + bb + ((fop == 4'd1) ? 17'(fci) : 17'd0);
                fc = t[w];
                r  = t & msk;
                fv = (aa[w-1] == bb[w-1]) && (r[w-1] != aa[w-1]);
            end
            4'd2, 4'd3: begin
                t  = aa - bb - ((fop == 4'd3) ? 17'(fci) : 17'd0);
                fc = t[w];
                r  = t & msk;
                fv = (aa[w-1] != bb[w-1]) && (r[w-1] != aa[w-1]);
            end
            4'd4: r = aa & bb;
            4'd5: r = aa | bb;
            4'd6: r = aa ^ bb;
            4'd7: r = ~aa & msk;
            default: begin
                for (int i = 0; i < int'(fk); i++) begin
                    sg = r[w-1];
                    case (fop)
                        4'd8:  begin fc = r[w-1]; r = (r << 1) & msk; end
                        4'd9:  begin fc = r[0];   r = r >> 1; end
                        4'd10: begin fc = r[0];   r = (r >> 1) | (17'(sg) << (w-1)); end
                        4'd11: begin fc = r[w-1]; r = ((r << 1) | 17'(fc)) & msk; end
                        default: begin fc = r[0]; r = (r >> 1) | (17'(fc) << (w-1)); end
                    endcase
                end
            end
        endcase
        fz = (r == 17'd0);
        fn = r[w-1];
        return {(fbm ? {fa[15:8], r[7:0]} : r[15:0]), fz, fn, fc, fv};
    endfunction

    task automatic run(input string tag, input logic [3:0] top, input logic [15:0] ta,
                       input logic [15:0] tb, input logic tci, input logic tbm,
                       input logic [3:0] tk);
        logic [19:0] exp, act;
        @(negedge clk);
        op = top; a = ta; b = tb; ci = tci; bm = tbm; k = tk;
        #2;
        exp = model(top, ta, tb, tci, tbm, tk);
        act = {res, z, n, c, v};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h ci=%b byte=%b k=%0d: actual res=%h znCV=%b expected res=%h znCV=%b",
                     tag, top, ta, tb, tci, tbm, tk, act[19:4], act[3:0], exp[19:4], exp[3:0]);
        end
    endtask

    task automatic t_idle();
        run("R6 idle", 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_add();
        run("R1", 4'd0, 16'h1234, 16'h4321, 1'b0, 1'b0, 4'd0);
        run("R1", 4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 4'd0);
        run("R1", 4'd1, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd0);
        run("R1", 4'd1, 16'h00FF, 16'h0000, 1'b1, 1'b1, 4'd0);
    endtask

    task automatic t_sub();
        run("R2", 4'd2, 16'h0005, 16'h0007, 1'b0, 1'b0, 4'd0);
        run("R2", 4'd3, 16'h1000, 16'h1000, 1'b1, 1'b0, 4'd0);
        run("R2", 4'd3, 16'h1000, 16'h1000, 1'b0, 1'b0, 4'd0);
        run("R2", 4'd3, 16'hAB10, 16'h0010, 1'b1, 1'b1, 4'd0);
    endtask

    task automatic t_overflow();
        run("R3", 4'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 4'd0);
        run("R3", 4'd2, 16'h8000, 16'h0001, 1'b0, 1'b0, 4'd0);
        run("R3", 4'd0, 16'h007F, 16'h0001, 1'b0, 1'b1, 4'd0);
        run("R3", 4'd2, 16'h0080, 16'h0001, 1'b0, 1'b1, 4'd0);
    endtask

    task automatic t_logic();
        for (int o = 4; o < 8; o++) begin
            run("R4", 4'(o), 16'hF0F0, 16'hFF00, 1'b0, 1'b0, 4'd0);
            run("R4", 4'(o), 16'h5A3C, 16'h0FF0, 1'b1, 1'b1, 4'd0);
        end
    endtask

    task automatic t_byte();
        run("R5", 4'd0, 16'hAA80, 16'h5580, 1'b0, 1'b1, 4'd0);
        run("R5", 4'd4, 16'hFF0F, 16'h00F0, 1'b0, 1'b1, 4'd0);
        run("R5", 4'd7, 16'h1200, 16'h0000, 1'b0, 1'b1, 4'd0);
        run("R6", 4'd4, 16'h8000, 16'hFF00, 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_shifts_word();
        for (int s = 0; s < 16; s++) begin
            run("R7 shl", 4'd8,  16'hB3C5, 16'h0, 1'b0, 1'b0, 4'(s));
            run("R7 shr", 4'd9,  16'hB3C5, 16'h0, 1'b0, 1'b0, 4'(s));
            run("R8 asr", 4'd10, 16'hB3C5, 16'h0, 1'b0, 1'b0, 4'(s));
            run("R9 rol", 4'd11, 16'hB3C5, 16'h0, 1'b0, 1'b0, 4'(s));
            run("R9 ror", 4'd12, 16'hB3C5, 16'h0, 1'b0, 1'b0, 4'(s));
        end
    endtask

    task automatic t_zero_amt();
        for (int o = 8; o < 13; o++) begin
            run("R10", 4'(o), 16'hFFFF, 16'h0, 1'b1, 1'b0, 4'd0);
            run("R10", 4'(o), 16'h9C81, 16'h0, 1'b0, 1'b1, 4'd0);
        end
    endtask

    task automatic t_byte_shifts();
        for (int s = 0; s < 16; s++) begin
            for (int o = 8; o < 13; o++) begin
                run("R11", 4'(o), 16'h7E96, 16'h0, 1'b0, 1'b1, 4'(s));
                run("R11", 4'(o), 16'hC34B, 16'h0, 1'b0, 1'b1, 4'(s));
            end
        end
    endtask

    task automatic t_undefined();
        for (int o = 13; o < 16; o++) begin
            run("R12", 4'(o), 16'h8000, 16'h1234, 1'b1, 1'b0, 4'd3);
            run("R12", 4'(o), 16'h0000, 16'hFFFF, 1'b0, 1'b1, 4'd7);
        end
    endtask

    task automatic t_cin_ignored();
        for (int o = 0; o < 13; o++) begin
            if (o == 1 || o == 3) continue;
            run("R13", 4'(o), 16'h7F01, 16'h80FE, 1'b1, 1'b0, 4'd5);
            run("R13", 4'(o), 16'h7F01, 16'h80FE, 1'b1, 1'b1, 4'd5);
        end
    endtask

    task automatic t_sweep();
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run("R1..sweep", lf[3:0], lf, {lf[7:0], lf[15:8]}, lf[5], lf[9], lf[12:9]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; op = '0; bm = 1'b0; ci = 1'b0; k = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_overflow();
        t_logic();
        t_byte();
        t_shifts_word();
        t_zero_amt();
        t_byte_shifts();
        t_undefined();
        t_cin_ignored();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule